// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as a set of packed-BCD counters (seconds, minutes, hours, day of month, month and a two-digit year standing for 2000 to 2099), always in 24-hour form. A slow oscillator enable `tick_i` pulses once per oscillator period. A prescaler turns `PRESCALE` of those pulses into one second step, and a single-cycle carry chain ripples that step through all six fields. The chain knows month lengths and leap years.

Software reaches the block through a byte-wide register port. The time fields sit at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds up to year). The alarm fields use the same order at 0x20 to 0x34. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Reads are combinational from `addr_i`, and a write takes effect on the clock edge where `wr_en_i` is high. There is no data stream through the block, so the port has no valid/ready handshake and no back-pressure: every access completes in one cycle.

Status shows a busy warning during the last oscillator period before each update, plus sticky event flags. The interrupt line combines the alarm and one-second flags with their enables.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. Control, status and interrupt enable read 0x00, and `irq_o` is low.
- R2: Control bit 0 set to 1 lets the clock run and 0 freezes both time and prescaler. Status bit 1 reflects it. Control bit 3 (hour format) and every other control bit read 0 whatever is written.
- R3: The seconds field advances once every `PRESCALE` ticks. A write to any time register loads that field at once and restarts the prescaler, so the next advance comes `PRESCALE` ticks after the write.
- R4: Seconds wrap from 59 to 00 and carry into minutes, minutes wrap from 59 to 00 and carry into hours, and hours wrap from 23 to 00 and carry into the day. Every digit stays in BCD.
- R5: The day wraps to 01 after the month's last day and carries into the month. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. Month 02 has 29 days when the year is divisible by four and 28 otherwise. Month 12 wraps to 01 and carries into the year, and the year wraps from 99 to 00.
- R6: Status bit 0 (busy) is 1 exactly while the clock runs and the prescaler sits in its final tick period before an update.
- R7: Status bits 2, 3, 4 and 5 are set by a second step, a minute carry, an hour carry and a day carry respectively. They stay set until software writes 1 to that bit. Writing 0 leaves them unchanged.
- R8: Status bit 6 (alarm) is set once when all six alarm fields become equal to the time fields, and is cleared by writing 1 to it. There are no wildcard fields, so one differing field, the year included, prevents the alarm.
- R9: `irq_o` equals (status bit 6 AND enable bit 3) OR (status bit 2 AND enable bit 2), with the enable register at 0x48. It stays high until the flag is cleared.
- R10: Alarm registers read back the value written. Addresses outside the map read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per oscillator period |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded assertions are checked on every cycle:
- a frozen clock holds its time;
- a prescaler restart clears busy;
- busy persists until the next tick;
- an alarm hit sets the flag;
- a write-one clear removes a flag.

Only the bench's scenarios can show the following:
- the calendar arithmetic itself, that is the month lengths, the leap-year February and the year wrap;
- the exact count of ticks between a time write and the next step;
- that an alarm differing only in its year never fires.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 6;  // sec, min, hour, day, month, year

  typedef logic [NFIELD-1:0][7:0] date_t;

  localparam logic [2:0] OFS_TIME_HI  = 3'b000;  // 0x00..0x14
  localparam logic [2:0] OFS_ALARM_HI = 3'b001;  // 0x20..0x34
  localparam logic [7:0] OFS_CTRL     = 8'h40;
  localparam logic [7:0] OFS_STAT     = 8'h44;
  localparam logic [7:0] OFS_IEN      = 8'h48;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'h0, yr[7:4]} * 8'd10) + {4'h0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_limit(input int idx, input logic [7:0] mon,
                                             input logic [7:0] yr);
    case (idx)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return last_day(mon, yr);
      4:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] field_base(input int idx);
    return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768  // must be at least 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic sec_tick_o,
  output logic busy_o
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last    = (cnt_q == CNT_LAST);
  assign busy_o     = run_i && at_last;
  assign sec_tick_o = run_i && tick_i && at_last && !restart_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R3: a restart always leaves the prescaler out of its final period
  p_restart_clears_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !busy_o);

  // R6: busy persists while no tick and no restart arrive
  p_busy_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !restart_i && run_i) |=> busy_o);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  output date_t      time_o,
  output logic [3:0] roll_o     // {day, hour, min, sec} events
);
  date_t            t_q, t_nxt;
  logic [NFIELD:0]  carry;

  always_comb begin
    logic c;
    logic w;
    c = step_i;
    carry = '0;
    carry[0] = step_i;
    for (int i = 0; i < NFIELD; i++) begin
      w = (t_q[i] == field_limit(i, t_q[4], t_q[5]));
      t_nxt[i] = c ? (w ? field_base(i) : bcd_inc(t_q[i])) : t_q[i];
      c = c & w;
      carry[i+1] = c;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFIELD; i++) t_q[i] <= field_base(i);
    end else if (wr_en_i) begin
      t_q[wr_idx_i] <= wr_data_i;
    end else if (step_i) begin
      t_q <= t_nxt;
    end
  end

  assign time_o = t_q;
  assign roll_o = (wr_en_i) ? 4'b0000 : carry[3:0];

  // R2: without a step or a load the time does not move
  p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !wr_en_i) |=> $stable(time_o));

  // R4: seconds at 59 wrap to 00 on a step
  p_sec_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_en_i && time_o[0] == 8'h59) |=> (time_o[0] == 8'h00));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  date_t      now_i,
  output date_t      alarm_o,
  output logic       hit_o
);
  date_t             al_q;
  logic [NFIELD-1:0] eq;
  logic              match, match_q;

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
      assign eq[g] = (al_q[g] == now_i[g]);
    end
  endgenerate

  assign match = &eq;
  assign hit_o = match && !match_q;
  assign alarm_o = al_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      al_q    <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (wr_en_i) al_q[wr_idx_i] <= wr_data_i;
    end
  end

  // R8: a hit is a single-cycle event per match
  p_hit_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  localparam int NFLAG = 5;  // status bits 2..6

  logic             in_field, is_time, is_alarm;
  logic [2:0]       fidx;
  logic             time_wr, alarm_wr, stat_wr;
  logic             run_q, ien_alarm_q, ien_timer_q;
  logic [NFLAG-1:0] flag_q, flag_set, flag_clr;
  logic             sec_tick, busy, alarm_hit;
  logic [3:0]       roll;
  date_t            now, alarm;

  assign fidx     = addr_i[4:2];
  assign in_field = (addr_i[1:0] == 2'b00) && (fidx < 3'(NFIELD));
  assign is_time  = in_field && (addr_i[7:5] == OFS_TIME_HI);
  assign is_alarm = in_field && (addr_i[7:5] == OFS_ALARM_HI);
  assign time_wr  = wr_en_i && is_time;
  assign alarm_wr = wr_en_i && is_alarm;
  assign stat_wr  = wr_en_i && (addr_i == OFS_STAT);

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i, .restart_i(time_wr),
    .sec_tick_o(sec_tick), .busy_o(busy)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni, .step_i(sec_tick), .wr_en_i(time_wr), .wr_idx_i(fidx),
    .wr_data_i, .time_o(now), .roll_o(roll)
  );

  rtc_alarm_cmp u_alm (
    .clk_i, .rst_ni, .wr_en_i(alarm_wr), .wr_idx_i(fidx), .wr_data_i,
    .now_i(now), .alarm_o(alarm), .hit_o(alarm_hit)
  );

  assign flag_set = {alarm_hit, roll};
  assign flag_clr = stat_wr ? wr_data_i[6:2] : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      ien_alarm_q <= 1'b0;
      ien_timer_q <= 1'b0;
      flag_q      <= '0;
    end else begin
      if (wr_en_i && addr_i == OFS_CTRL) run_q <= wr_data_i[0];
      if (wr_en_i && addr_i == OFS_IEN) begin
        ien_alarm_q <= wr_data_i[3];
        ien_timer_q <= wr_data_i[2];
      end
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (is_time)                  rd_data_o = now[fidx];
    else if (is_alarm)            rd_data_o = alarm[fidx];
    else if (addr_i == OFS_CTRL)  rd_data_o = {7'b0, run_q};
    else if (addr_i == OFS_STAT)  rd_data_o = {1'b0, flag_q, run_q, busy};
    else if (addr_i == OFS_IEN)   rd_data_o = {4'b0, ien_alarm_q, ien_timer_q, 2'b00};
  end

  assign irq_o = (flag_q[4] && ien_alarm_q) || (flag_q[0] && ien_timer_q);

  // R8: a full match always raises the alarm flag
  p_alarm_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit |=> flag_q[4]);

  // R7: writing one to a flag clears it unless a new event arrives
  p_w1c_sec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wr_data_i[2] && !roll[0]) |=> !flag_q[0]);

  // R9: a disabled source never drives the interrupt
  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_alarm_q && !ien_timer_q) |-> !irq_o);

endmodule

// File: tb/rtc_bcd_calendar_bench.sv
module rtc_bcd_calendar_bench;
  localparam int PS = 4;

  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] addr = 0, wr_data = 0, rd_data;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar #(.PRESCALE(PS)) u_rtc_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk); #1 check(req, {7'b0, irq}, {7'b0, exp});
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic set_alarm(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d); wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask

  task automatic t_reset;
    chk_reg("R1 sec", 8'h00, 8'h00);
    chk_reg("R1 day", 8'h0C, 8'h01);
    chk_reg("R1 month", 8'h10, 8'h01);
    chk_reg("R1 year", 8'h14, 8'h00);
    chk_reg("R1 ctrl", 8'h40, 8'h00);
    chk_reg("R1 status", 8'h44, 8'h00);
    chk_reg("R1 ien", 8'h48, 8'h00);
    chk_irq("R1 irq", 1'b0);
  endtask

  task automatic t_control;
    ticks(2 * PS);
    chk_reg("R2 stopped sec", 8'h00, 8'h00);
    wr(8'h40, 8'hFF);
    chk_reg("R2 ctrl readback", 8'h40, 8'h01);
    chk_reg("R2 run bit", 8'h44, 8'h02);
  endtask

  task automatic t_prescale;
    wr(8'h00, 8'h10);
    ticks(2);
    wr(8'h00, 8'h10);          // restart mid-second
    ticks(PS - 1);
    chk_reg("R3 no step yet", 8'h00, 8'h10);
    chk_reg("R6 busy set", 8'h44, 8'h03);
    ticks(1);
    chk_reg("R3 stepped", 8'h00, 8'h11);
    wr(8'h44, 8'h7C);
    chk_reg("R6 busy clear", 8'h44, 8'h02);
  endtask

  task automatic t_hms;
    set_time(8'h00, 8'h01, 8'h01, 8'h23, 8'h59, 8'h58);
    wr(8'h44, 8'h7C);
    ticks(PS);
    chk_reg("R4 sec 59", 8'h00, 8'h59);
    ticks(PS);
    chk_reg("R4 sec wrap", 8'h00, 8'h00);
    chk_reg("R4 min wrap", 8'h04, 8'h00);
    chk_reg("R4 hour wrap", 8'h08, 8'h00);
    chk_reg("R4 day carry", 8'h0C, 8'h02);
    chk_reg("R7 all events", 8'h44, 8'h3E);
    wr(8'h44, 8'h00);
    chk_reg("R7 write zero kept", 8'h44, 8'h3E);
    wr(8'h44, 8'h04);
    chk_reg("R7 sec cleared", 8'h44, 8'h3A);
  endtask

  task automatic roll_day(input string req, input logic [7:0] y, mo, d,
                          input logic [7:0] ey, emo, ed);
    set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
    ticks(PS);
    chk_reg({req, " day"}, 8'h0C, ed);
    chk_reg({req, " month"}, 8'h10, emo);
    chk_reg({req, " year"}, 8'h14, ey);
  endtask

  task automatic t_months;
    roll_day("R5 year wrap", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
    roll_day("R5 leap 28", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    roll_day("R5 leap 29", 8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    roll_day("R5 common feb", 8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    roll_day("R5 april", 8'h25, 8'h04, 8'h30, 8'h25, 8'h05, 8'h01);
    roll_day("R5 jan 30", 8'h25, 8'h01, 8'h30, 8'h25, 8'h01, 8'h31);
  endtask

  task automatic t_alarm;
    wr(8'h48, 8'h08);
    set_alarm(8'h25, 8'h06, 8'h15, 8'h12, 8'h30, 8'h02);
    set_time(8'h25, 8'h06, 8'h15, 8'h12, 8'h30, 8'h00);
    wr(8'h44, 8'h7C);
    ticks(PS);
    chk_reg("R8 not yet", 8'h44, 8'h06);
    chk_irq("R9 irq low", 1'b0);
    ticks(PS);
    chk_reg("R8 alarm flag", 8'h44, 8'h46);
    chk_irq("R9 irq alarm", 1'b1);
    wr(8'h44, 8'h40);
    chk_irq("R9 irq cleared", 1'b0);
    chk_reg("R8 flag cleared", 8'h44, 8'h06);
    chk_reg("R10 alarm sec", 8'h20, 8'h02);
    chk_reg("R10 alarm year", 8'h34, 8'h25);
  endtask

  task automatic t_no_wildcard;
    wr(8'h34, 8'h26);
    set_time(8'h25, 8'h06, 8'h15, 8'h12, 8'h30, 8'h00);
    wr(8'h44, 8'h7C);
    ticks(3 * PS);
    chk_reg("R8 year differs", 8'h44, 8'h06);
  endtask

  task automatic t_timer_irq;
    wr(8'h48, 8'h04);
    wr(8'h44, 8'h7C);
    chk_irq("R9 timer idle", 1'b0);
    ticks(PS);
    chk_irq("R9 timer irq", 1'b1);
    repeat (3) @(negedge clk);
    chk_irq("R9 timer held", 1'b1);
    wr(8'h44, 8'h04);
    chk_irq("R9 timer cleared", 1'b0);
  endtask

  task automatic t_unmapped;
    wr(8'h3C, 8'hAA);
    chk_reg("R10 unmapped 3C", 8'h3C, 8'h00);
    chk_reg("R10 unmapped 18", 8'h18, 8'h00);
    chk_reg("R10 ien readback", 8'h48, 8'h04);
  endtask

  initial begin
    logic timed_out;
    timed_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset; t_control; t_prescale; t_hms; t_months;
        t_alarm; t_no_wildcard; t_timer_irq; t_unmapped;
      end
      begin
        repeat (50000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule